// File: doc/BRIEF.md
# Watchdog Timer with Register Interface

This block is a watchdog built around a 32-bit up-counter that advances through a programmable prescaler. A single clock runs both the register port and the counting logic. A tick-enable input marks the cycles in which the slow time base advances. Software programs the block through a flat, word-addressed register port. That port covers control, live counter readback, a reload value, a reload trigger, a keyed start/stop register, a delay compare value, event status, and event enables. The enables are changed through separate set and clear registers.

When the counter steps past its all-ones value, it reloads from the load register and keeps counting. It raises an overflow event and pulls an active-low reset output low for a fixed number of cycles. It also raises a second event when a step lands on the programmed delay value. The active-low interrupt output is asserted while any pending event is also enabled. Starting and stopping the counter each need a two-write key sequence. A reload needs a trigger write whose value differs from the previous trigger write, so a stuck or repeated software write cannot keep the watchdog alive.

The register port is a plain, single-cycle control port: a write takes effect at the clock edge where `reg_wr` is high, and `reg_rdata` follows `reg_addr` combinationally. There is no data stream and no back-pressure.

Top module: `wdt_top`

## Requirements
- R1: After reset every register reads 0, the counter is stopped, and both `wdt_rst_n` and `wdt_irq_n` are high.
- R2: The prescaler is controlled by control bit 5 (enable) and control bits [4:2] (ratio field r). With bit 5 clear, the counter advances once per tick. With bit 5 set, it advances once every 2^r ticks.
- R3: Writing 0xBBBB then 0x4444 to the start/stop register starts the counter, and writing 0xAAAA then 0x5555 stops it. Any other pair of consecutive writes leaves the running state unchanged.
- R4: A stopped counter keeps its value whatever the tick input does.
- R5: Writing the load register never changes the counter directly. A trigger write whose value differs from the previous trigger write loads the counter from the load register and restarts the prescaler phase. A trigger write equal to the previous one has no effect.
- R6: A step from all-ones reloads the counter from the load register and sets status bit 0 (overflow).
- R7: A step that makes the counter equal the delay register sets status bit 1 (delay reached).
- R8: After an overflow step, `wdt_rst_n` is low for exactly 4 clock cycles, starting in the cycle after that step.
- R9: Writing 1 to a bit of the enable-set register enables that event, and writing 1 to a bit of the enable-clear register disables it. Bit 0 is overflow and bit 1 is delay. Reading either register returns the current enables.
- R10: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R11: `wdt_irq_n` is low exactly while some status bit and its enable bit are both 1.
- R12: The counter register is read-only: writes to it are ignored, and it returns the live count while running.
- R13: The word addresses are 0 control, 1 counter, 2 load, 3 trigger, 4 start/stop, 5 delay, 6 status, 7 enable-set and 8 enable-clear. The control register reads back bits [5:2] as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register port and the counter |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Time-base tick; the prescaler advances only when high |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| wdt_rst_n | output | 1 | Active-low reset pulse after overflow |
| wdt_irq_n | output | 1 | Active-low interrupt: pending and enabled event |

## Verification
The bench sweeps both prescaler modes and all eight ratio values over a fixed tick count, and compares the count against the arithmetic quotient. An off-by-one in the divider phase, or a mishandled ratio of 7, shows up there as a wrong count. It drives the counter across all-ones and measures the reset pulse edge by edge. A design that skips the reload, or sizes the pulse wrongly, reports a wrong count or a wrong `wdt_rst_n` level. Mismatched key pairs, repeated trigger values and load writes during counting are each followed by tick activity and a counter read, which catches any design that accepts a bad sequence. The delay match, the single-bit status clear and the enable masking are checked through the interrupt pin.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_AW = 4;
  localparam int NEVT   = 2;
  localparam int EVT_OVF = 0;
  localparam int EVT_DLY = 1;
  localparam int CTRL_RATIO_LSB = 2;
  localparam int CTRL_PRE_BIT   = 5;

  localparam logic [REG_AW-1:0] A_CTRL  = 4'd0;
  localparam logic [REG_AW-1:0] A_COUNT = 4'd1;
  localparam logic [REG_AW-1:0] A_LOAD  = 4'd2;
  localparam logic [REG_AW-1:0] A_TRIG  = 4'd3;
  localparam logic [REG_AW-1:0] A_RUN   = 4'd4;
  localparam logic [REG_AW-1:0] A_DELAY = 4'd5;
  localparam logic [REG_AW-1:0] A_STAT  = 4'd6;
  localparam logic [REG_AW-1:0] A_ENSET = 4'd7;
  localparam logic [REG_AW-1:0] A_ENCLR = 4'd8;

  localparam logic [15:0] KEY_GO_FIRST   = 16'hBBBB;
  localparam logic [15:0] KEY_GO_SECOND  = 16'h4444;
  localparam logic [15:0] KEY_HALT_FIRST = 16'hAAAA;
  localparam logic [15:0] KEY_HALT_SECOND= 16'h5555;

  typedef enum logic [1:0] {RUN_KEEP, RUN_GO, RUN_HALT} run_cmd_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             running,
  input  logic             restart,
  input  logic             pre_en,
  input  logic [PRE_W-1:0] ratio,
  output logic             step
);
  localparam int PCNT_W = (1 << PRE_W) - 1;

  logic [PCNT_W-1:0] phase_q;
  logic [PCNT_W-1:0] limit;
  logic              at_limit;

  always_comb begin
    if (pre_en) limit = (PCNT_W'(1) << ratio) - PCNT_W'(1);
    else        limit = '0;
  end

  assign at_limit = (phase_q >= limit);
  assign step     = running && tick_en && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase_q <= '0;
    else if (!running || restart) phase_q <= '0;
    else if (tick_en)           phase_q <= at_limit ? '0 : phase_q + PCNT_W'(1);
  end
endmodule

// File: rtl/wdt_runctl.sv
module wdt_runctl #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic [DW-1:0] key_data,
  output logic [DW-1:0] last_key,
  output logic          running
);
  import wdt_pkg::*;

  run_cmd_e cmd;

  always_comb begin
    cmd = RUN_KEEP;
    if (key_wr) begin
      if (last_key == DW'(KEY_GO_FIRST) && key_data == DW'(KEY_GO_SECOND))
        cmd = RUN_GO;
      else if (last_key == DW'(KEY_HALT_FIRST) && key_data == DW'(KEY_HALT_SECOND))
        cmd = RUN_HALT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_key <= '0;
      running  <= 1'b0;
    end else begin
      if (key_wr) last_key <= key_data;
      case (cmd)
        RUN_GO:   running <= 1'b1;
        RUN_HALT: running <= 1'b0;
        default:  running <= running;
      endcase
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] delay_val,
  output logic [CNT_W-1:0] count,
  output logic             ovf_evt,
  output logic             dly_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] next_val;
  logic             wraps;

  assign wraps    = (count == CNT_MAX);
  assign next_val = wraps ? load_val : count + CNT_W'(1);
  assign ovf_evt  = step && !reload && wraps;
  assign dly_evt  = step && !reload && (next_val == delay_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (reload) count <= load_val;
    else if (step)   count <= next_val;
  end
endmodule

// File: rtl/wdt_rstgen.sv
module wdt_rstgen #(
  parameter int RST_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_n
);
  localparam int RC_W = $clog2(RST_CYC + 1);

  logic [RC_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain_q <= '0;
    else if (fire)           remain_q <= RC_W'(RST_CYC);
    else if (remain_q != '0) remain_q <= remain_q - RC_W'(1);
  end

  assign pulse_n = (remain_q == '0);
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 3,
  parameter int NEVT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] last_key,
  input  logic [NEVT-1:0]  evt,
  output logic             pre_en,
  output logic [PRE_W-1:0] ratio,
  output logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] delay_val,
  output logic             reload,
  output logic             key_wr,
  output logic [NEVT-1:0]  status,
  output logic [NEVT-1:0]  enables
);
  import wdt_pkg::*;

  logic [CNT_W-1:0] trig_q;
  logic wr_ctrl, wr_load, wr_trig, wr_delay, wr_stat, wr_set, wr_clr;

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_load  = reg_wr && (reg_addr == A_LOAD);
  assign wr_trig  = reg_wr && (reg_addr == A_TRIG);
  assign wr_delay = reg_wr && (reg_addr == A_DELAY);
  assign wr_stat  = reg_wr && (reg_addr == A_STAT);
  assign wr_set   = reg_wr && (reg_addr == A_ENSET);
  assign wr_clr   = reg_wr && (reg_addr == A_ENCLR);
  assign key_wr   = reg_wr && (reg_addr == A_RUN);
  assign reload   = wr_trig && (reg_wdata != trig_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_en    <= 1'b0;
      ratio     <= '0;
      load_val  <= '0;
      delay_val <= '0;
      trig_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        pre_en <= reg_wdata[CTRL_PRE_BIT];
        ratio  <= reg_wdata[CTRL_RATIO_LSB +: PRE_W];
      end
      if (wr_load)  load_val  <= reg_wdata;
      if (wr_delay) delay_val <= reg_wdata;
      if (wr_trig)  trig_q    <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= '0;
      enables <= '0;
    end else begin
      for (int i = 0; i < NEVT; i++) begin
        if (evt[i])                       status[i] <= 1'b1;
        else if (wr_stat && reg_wdata[i]) status[i] <= 1'b0;
        if (wr_set && reg_wdata[i])       enables[i] <= 1'b1;
        else if (wr_clr && reg_wdata[i])  enables[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[CTRL_PRE_BIT]               = pre_en;
        reg_rdata[CTRL_RATIO_LSB +: PRE_W]    = ratio;
      end
      A_COUNT: reg_rdata = count;
      A_LOAD:  reg_rdata = load_val;
      A_TRIG:  reg_rdata = trig_q;
      A_RUN:   reg_rdata = last_key;
      A_DELAY: reg_rdata = delay_val;
      A_STAT:  reg_rdata[NEVT-1:0] = status;
      A_ENSET, A_ENCLR: reg_rdata[NEVT-1:0] = enables;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
  parameter int CNT_W   = 32,
  parameter int PRE_W   = 3,
  parameter int RST_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             wdt_rst_n,
  output logic             wdt_irq_n
);
  import wdt_pkg::*;

  logic             pre_en;
  logic [PRE_W-1:0] ratio;
  logic [CNT_W-1:0] load_val, delay_val, count, last_key;
  logic             reload, key_wr, running, step, ovf_evt, dly_evt;
  logic [NEVT-1:0]  evt, status, enables;

  assign evt[EVT_OVF] = ovf_evt;
  assign evt[EVT_DLY] = dly_evt;

  wdt_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .NEVT(NEVT)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count(count),
    .last_key(last_key), .evt(evt), .pre_en(pre_en), .ratio(ratio),
    .load_val(load_val), .delay_val(delay_val), .reload(reload),
    .key_wr(key_wr), .status(status), .enables(enables)
  );

  wdt_runctl #(.DW(CNT_W)) u_run (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(reg_wdata),
    .last_key(last_key), .running(running)
  );

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .running(running),
    .restart(reload), .pre_en(pre_en), .ratio(ratio), .step(step)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .reload(reload),
    .load_val(load_val), .delay_val(delay_val), .count(count),
    .ovf_evt(ovf_evt), .dly_evt(dly_evt)
  );

  wdt_rstgen #(.RST_CYC(RST_CYC)) u_rst (
    .clk(clk), .rst_n(rst_n), .fire(ovf_evt), .pulse_n(wdt_rst_n)
  );

  assign wdt_irq_n = ~|(status & enables);
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             running,
  input logic             reload,
  input logic             step,
  input logic             pre_en,
  input logic             ovf_evt,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] load_val,
  input logic [1:0]       enables,
  input logic             wdt_rst_n,
  input logic             wdt_irq_n
);
  assert_unity_ratio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick_en && !pre_en) |-> step);

  assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !reload) |=> $stable(count));

  assert_wrap_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !reload && count == '1) |=> (count == $past(load_val)));

  assert_rst_after_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> !wdt_rst_n);

  assert_rst_min_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst_n) |=> !wdt_rst_n);

  assert_irq_on_ovf_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && enables[0]) |=> !wdt_irq_n);
endmodule

bind wdt_top wdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .running(running),
  .reload(reload), .step(step), .pre_en(pre_en), .ovf_evt(ovf_evt),
  .count(count), .load_val(load_val), .enables(enables),
  .wdt_rst_n(wdt_rst_n), .wdt_irq_n(wdt_irq_n)
);

// File: tb/wdt_top_tb_top.sv
`timescale 1ns/1ps
module wdt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        wdt_rst_n, wdt_irq_n;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] trig_v = 32'd0;
  logic [31:0] v;

  always #10 clk = ~clk;

  wdt_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wdt_rst_n(wdt_rst_n), .wdt_irq_n(wdt_irq_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
    tick_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic keys(input logic [31:0] k1, input logic [31:0] k2);
    wr(4'd4, k1); wr(4'd4, k2);
  endtask

  task automatic retrigger();
    trig_v = trig_v + 32'd1;
    wr(4'd3, trig_v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] c0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R1 / R13: every register reads zero after reset
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v); check("R1 reset reg", v, 32'd0);
    end
    check("R1 rst_n", {31'd0, wdt_rst_n}, 32'd1);
    check("R1 irq_n", {31'd0, wdt_irq_n}, 32'd1);
    ticks(5); rd(4'd1, v); check("R1 stopped after reset", v, 32'd0);

    // R12: counter register ignores writes
    wr(4'd1, 32'h1234); rd(4'd1, v); check("R12 count write ignored", v, 32'd0);

    // R2 / R13: sweep both prescaler modes and all ratios
    for (int pe = 0; pe < 2; pe++) begin
      for (int r = 0; r < 8; r++) begin
        keys(32'hAAAA, 32'h5555);
        retrigger();
        wr(4'd0, (32'(pe) << 5) | (32'(r) << 2));
        rd(4'd0, v); check("R13 ctrl readback", v, (32'(pe) << 5) | (32'(r) << 2));
        keys(32'hBBBB, 32'h4444);
        ticks(300);
        rd(4'd1, v);
        check("R2 prescaled count", v, (pe != 0) ? (32'd300 >> r) : 32'd300);
      end
    end

    // R3: wrong key pairs do not start
    wr(4'd0, 32'd0);
    keys(32'hAAAA, 32'h5555);
    retrigger();
    keys(32'hBBBB, 32'h5555); ticks(10); rd(4'd1, v); check("R3 BBBB/5555 no start", v, 32'd0);
    keys(32'hAAAA, 32'h4444); ticks(10); rd(4'd1, v); check("R3 AAAA/4444 no start", v, 32'd0);
    wr(4'd4, 32'hBBBB); wr(4'd4, 32'h1234); wr(4'd4, 32'h4444);
    ticks(10); rd(4'd1, v); check("R3 broken pair no start", v, 32'd0);
    keys(32'hBBBB, 32'h4444); ticks(7); rd(4'd1, v); check("R3 start", v, 32'd7);
    keys(32'hAAAA, 32'h4444); ticks(3); rd(4'd1, v); check("R3 bad stop ignored", v, 32'd10);
    keys(32'hAAAA, 32'h5555); ticks(9); rd(4'd1, v); check("R4 stopped holds", v, 32'd10);

    // R5: load write does not touch counter; trigger rules
    keys(32'hBBBB, 32'h4444);
    wr(4'd2, 32'd1000); rd(4'd1, v); check("R5 load no direct effect", v, 32'd10);
    ticks(3); rd(4'd1, v); check("R12 live count", v, 32'd13);
    wr(4'd3, trig_v); rd(4'd1, v); check("R5 same trigger ignored", v, 32'd13);
    retrigger(); rd(4'd1, v); check("R5 new trigger reloads", v, 32'd1000);
    ticks(2); rd(4'd1, v); check("R5 counting after reload", v, 32'd1002);

    // R9 enable set/clear
    wr(4'd7, 32'd1); rd(4'd8, v); check("R9 enable set", v, 32'd1);

    // R6 / R8 / R11 overflow
    wr(4'd2, 32'hFFFF_FFFD); retrigger();
    rd(4'd6, v); check("R6 no early flag", v, 32'd0);
    ticks(2); rd(4'd1, v); check("R6 at max", v, 32'hFFFF_FFFF);
    check("R8 rst high before ovf", {31'd0, wdt_rst_n}, 32'd1);
    ticks(1);
    rd(4'd1, v); check("R6 wrap reload", v, 32'hFFFF_FFFD);
    rd(4'd6, v); check("R6 ovf flag", v, 32'd1);
    check("R11 irq low", {31'd0, wdt_irq_n}, 32'd0);
    check("R8 rst low cycle1", {31'd0, wdt_rst_n}, 32'd0);
    idle(3); check("R8 rst low cycle4", {31'd0, wdt_rst_n}, 32'd0);
    idle(1); check("R8 rst released", {31'd0, wdt_rst_n}, 32'd1);

    // R10 status clear
    wr(4'd6, 32'd2); rd(4'd6, v); check("R10 other bit kept", v, 32'd1);
    wr(4'd6, 32'd1); rd(4'd6, v); check("R10 w1c", v, 32'd0);
    check("R11 irq released", {31'd0, wdt_irq_n}, 32'd1);

    // R7 / R9 / R11 delay event with masking
    wr(4'd7, 32'd2); wr(4'd8, 32'd1);
    rd(4'd7, v); check("R9 enables after clear", v, 32'd2);
    wr(4'd2, 32'd0); wr(4'd5, 32'd5); retrigger();
    ticks(4); rd(4'd6, v); check("R7 not yet", v, 32'd0);
    check("R11 irq idle", {31'd0, wdt_irq_n}, 32'd1);
    ticks(1); rd(4'd6, v); check("R7 delay flag", v, 32'd2);
    rd(4'd1, c0); check("R7 count at delay", c0, 32'd5);
    check("R11 irq on delay", {31'd0, wdt_irq_n}, 32'd0);
    wr(4'd8, 32'd2); check("R11 masked", {31'd0, wdt_irq_n}, 32'd1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule